// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block models a synchronous static RAM with a two-stage pipeline. Address and control are registered on a rising clock edge, and the data for that operation moves two edges later. Reads and writes use the same two-edge distance, so a controller can place a write directly after a read, or a read directly after a write, and the shared data bus never needs an idle cycle. The bus is split into an input, an output and an output-enable signal; a wrapper joins them into a tristate pin.

A clock enable stalls the whole pipeline. Three chip selects gate the start of a new operation. A load/advance strobe either loads a new address or steps an internal four-word linear burst. Per-byte write selects choose which lanes a write updates. An asynchronous output enable can force the output driver off. When a read follows a write to the same word on the next edge, a forwarding path returns the newer data.

Top module: `zbt_sram`

## Requirements
- R1: A read sampled at edge E0 (clock enable low) loads `data_o` and raises `data_oe_o` at edge E1. Both stay there until the next enabled edge, so a controller samples the data at E2.
- R2: A write sampled at edge E0 takes `data_i` at edge E2, which is two enabled edges after its address.
- R3: Reads and writes can alternate on every enabled edge with no idle cycle, and every read still returns the correct word.
- R4: On a write, byte lane b (bits b*8+7..b*8) is updated only when `bw_ni[b]` is 0. Lanes whose select is 1 keep their old contents.
- R5: While `cen_ni` is 1, all inputs are ignored. Every pipeline register and output holds its value, and no array write occurs. The stall may last any number of cycles.
- R6: When `ld_ni` is 0 and any bit of `cs_ni` is 1, no operation starts and any burst ends. Operations already in the pipeline still complete. One enabled edge later, `data_oe_o` is 0 for that slot.
- R7: In the data slot of a write, `data_oe_o` is 0.
- R8: When `oe_ni` is 1, `data_oe_o` is 0 at once, without waiting for a clock edge.
- R9: A read sampled on the edge directly after a write to the same address returns the write data in the lanes that write selected, and the array contents in the other lanes.
- R10: A load with all three selects low (`cs_ni` = 000) starts a burst. Each following enabled edge with `ld_ni` = 1 issues one more operation in the same direction. Its address keeps the upper bits and adds 1, 2 and then 3 to the two low bits, wrapping modulo 4. After three such advances, further advances issue nothing.
- R11: After reset, `data_oe_o` is 0 and no operation is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_ni | input | 1 | Clock enable, active low; 1 stalls the pipeline |
| cs_ni | input | 3 | Chip selects, all active low |
| ld_ni | input | 1 | 0 loads a new address, 1 advances the burst |
| we_ni | input | 1 | 0 write, 1 read |
| bw_ni | input | BYTES | Byte write selects, active low |
| addr_i | input | ADDR_W | Word address |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| data_i | input | BYTES*BYTE_W | Write data from the bus |
| data_o | output | BYTES*BYTE_W | Read data to the bus |
| data_oe_o | output | 1 | Bus driver enable |

## Verification
The bench builds the block with a 16-word array and two byte lanes. At that size it can fill and read back every address. It can also try every byte-select combination and put a forwarding read behind a write at every address. Four-word bursts that wrap inside their group of four can start from offsets 1 and 2. A reference model in the bench commits writes and computes the expected output for every enabled edge. The bench mixes in stalls, deselects on each chip select in turn, and output-enable override.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef struct packed {
    logic vld;
    logic wr;
  } op_ctl_t;

  // linear burst step within a four-word group
  function automatic logic [1:0] burst_lo(input logic [1:0] base, input logic [1:0] cnt);
    return base + cnt + 2'd1;
  endfunction
endpackage

// File: rtl/zbt_issue.sv
module zbt_issue
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BYTES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cen_ni,
  input  logic [2:0]        cs_ni,
  input  logic              ld_ni,
  input  logic              we_ni,
  input  logic [BYTES-1:0]  bw_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output op_ctl_t           ctl_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTES-1:0]  mask_o
);
  op_ctl_t           ctl_q;
  logic [ADDR_W-1:0] addr_q, base_q;
  logic [BYTES-1:0]  mask_q;
  logic [1:0]        cnt_q;
  logic              act_q, bwr_q;
  logic              sel;

  assign sel = (cs_ni == 3'b000);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      addr_q <= '0;
      mask_q <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      bwr_q  <= 1'b0;
    end else if (!cen_ni) begin
      mask_q <= ~bw_ni;
      if (!ld_ni) begin
        ctl_q.vld <= sel;
        ctl_q.wr  <= ~we_ni;
        addr_q    <= addr_i;
        base_q    <= addr_i;
        bwr_q     <= ~we_ni;
        act_q     <= sel;
        cnt_q     <= '0;
      end else if (act_q && cnt_q != 2'd3) begin
        ctl_q.vld <= 1'b1;
        ctl_q.wr  <= bwr_q;
        addr_q    <= {base_q[ADDR_W-1:2], burst_lo(base_q[1:0], cnt_q)};
        cnt_q     <= cnt_q + 2'd1;
      end else begin
        ctl_q.vld <= 1'b0;
        act_q     <= 1'b0;
      end
    end
  end

  assign ctl_o  = ctl_q;
  assign addr_o = addr_q;
  assign mask_o = mask_q;

  // R6
  desel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && !ld_ni && cs_ni != 3'b000) |=> !ctl_q.vld);

  // R10
  burst_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && ld_ni && act_q && cnt_q == 2'd3) |=> (!ctl_q.vld && !act_q));
endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
  parameter int ADDR_W = 4,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 8,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int DATA_W = BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [BYTES-1:0]  wmask_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && wmask_i[b]) mem[waddr_i] <= wdata_i[b*BYTE_W +: BYTE_W];
    end

    assign rdata_o[b*BYTE_W +: BYTE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/zbt_stage2.sv
module zbt_stage2
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BYTES  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cen_ni,
  input  op_ctl_t           ctl_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTES-1:0]  mask_i,
  input  logic [DATA_W-1:0] rdata_i,
  output op_ctl_t           ctl_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTES-1:0]  mask_o,
  output logic [DATA_W-1:0] dout_o,
  output logic              drv_o
);
  op_ctl_t           ctl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTES-1:0]  mask_q;
  logic [DATA_W-1:0] dout_q;
  logic              drv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      addr_q <= '0;
      mask_q <= '0;
      dout_q <= '0;
      drv_q  <= 1'b0;
    end else if (!cen_ni) begin
      ctl_q  <= ctl_i;
      addr_q <= addr_i;
      mask_q <= mask_i;
      drv_q  <= ctl_i.vld && !ctl_i.wr;
      if (ctl_i.vld && !ctl_i.wr) dout_q <= rdata_i;
    end
  end

  assign ctl_o  = ctl_q;
  assign addr_o = addr_q;
  assign mask_o = mask_q;
  assign dout_o = dout_q;
  assign drv_o  = drv_q;

  // R1
  drv_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_q |-> (ctl_q.vld && !ctl_q.wr));

  // R5
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen_ni |=> ($stable(dout_q) && $stable(drv_q) && $stable(ctl_q) && $stable(addr_q)));
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 8,
  localparam int DATA_W = BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cen_ni,
  input  logic [2:0]        cs_ni,
  input  logic              ld_ni,
  input  logic              we_ni,
  input  logic [BYTES-1:0]  bw_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              oe_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  op_ctl_t           s1_ctl, s2_ctl;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [BYTES-1:0]  s1_mask, s2_mask;
  logic [DATA_W-1:0] arr_rdata, fwd_rdata, dout;
  logic              drv, commit, fwd_hit;

  zbt_issue #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_issue (
    .clk_i, .rst_ni, .cen_ni, .cs_ni, .ld_ni, .we_ni, .bw_ni, .addr_i,
    .ctl_o(s1_ctl), .addr_o(s1_addr), .mask_o(s1_mask)
  );

  assign commit = !cen_ni && s2_ctl.vld && s2_ctl.wr;

  zbt_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_array (
    .clk_i, .we_i(commit), .waddr_i(s2_addr), .wmask_i(s2_mask),
    .wdata_i(data_i), .raddr_i(s1_addr), .rdata_o(arr_rdata)
  );

  // write committing on the same edge as this read: take its lanes
  assign fwd_hit = s2_ctl.vld && s2_ctl.wr && (s2_addr == s1_addr);

  for (genvar b = 0; b < BYTES; b++) begin : g_fwd
    assign fwd_rdata[b*BYTE_W +: BYTE_W] = (fwd_hit && s2_mask[b]) ?
      data_i[b*BYTE_W +: BYTE_W] : arr_rdata[b*BYTE_W +: BYTE_W];
  end

  zbt_stage2 #(.ADDR_W(ADDR_W), .BYTES(BYTES), .DATA_W(DATA_W)) u_stage2 (
    .clk_i, .rst_ni, .cen_ni,
    .ctl_i(s1_ctl), .addr_i(s1_addr), .mask_i(s1_mask), .rdata_i(fwd_rdata),
    .ctl_o(s2_ctl), .addr_o(s2_addr), .mask_o(s2_mask), .dout_o(dout), .drv_o(drv)
  );

  assign data_o    = dout;
  assign data_oe_o = drv && !oe_ni;

  // R11
  always_comb begin
    if (!rst_ni) rst_quiet_chk: assert (!data_oe_o && !s1_ctl.vld && !s2_ctl.vld);
  end
endmodule

// File: tb/zbt_sram_tb.sv
module zbt_sram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int NB = 2;
  localparam int BW = 8;
  localparam int DW = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cen_ni = 1'b1;
  logic [2:0]    cs_ni = 3'b111;
  logic          ld_ni = 1'b0;
  logic          we_ni = 1'b1;
  logic [NB-1:0] bw_ni = '1;
  logic [AW-1:0] addr_i = '0;
  logic          oe_ni = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] data_o;
  logic          data_oe_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  // reference model state
  logic [DW-1:0] ref_mem [DEPTH];
  logic          m1_v = 0, m1_w = 0, m2_v = 0, m2_w = 0;
  logic [AW-1:0] m1_a = '0, m2_a = '0, b_base = '0;
  logic [NB-1:0] m1_m = '0, m2_m = '0;
  logic          b_act = 0, b_wr = 0;
  logic [1:0]    b_cnt = '0;
  logic          exp_drv = 0;
  logic [DW-1:0] exp_data = '0;

  zbt_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) u_dut (
    .clk_i, .rst_ni, .cen_ni, .cs_ni, .ld_ni, .we_ni, .bw_ni, .addr_i,
    .oe_ni, .data_i, .data_o, .data_oe_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    finish_run();
  end

  task automatic model_edge(logic ld, logic [2:0] cs, logic we, logic [NB-1:0] bw, logic [AW-1:0] a);
    if (m2_v && m2_w)
      for (int b = 0; b < NB; b++)
        if (m2_m[b]) ref_mem[m2_a][b*BW +: BW] = data_i[b*BW +: BW];
    exp_drv = m1_v && !m1_w;
    if (exp_drv) exp_data = ref_mem[m1_a];
    m2_v = m1_v; m2_w = m1_w; m2_a = m1_a; m2_m = m1_m;
    m1_m = ~bw;
    if (!ld) begin
      m1_v = (cs == 3'b000); m1_w = !we; m1_a = a;
      b_act = m1_v; b_base = a; b_wr = !we; b_cnt = 0;
    end else if (b_act && b_cnt != 2'd3) begin
      m1_v = 1; m1_w = b_wr;
      m1_a = {b_base[AW-1:2], 2'(b_base[1:0] + b_cnt + 2'd1)};
      b_cnt = b_cnt + 2'd1;
    end else begin
      m1_v = 0; b_act = 0;
    end
  endtask

  task automatic step(string tag, logic cen, logic ld, logic [2:0] cs, logic we,
                      logic [NB-1:0] bw, logic [AW-1:0] a, logic oe);
    cen_ni = cen; ld_ni = ld; cs_ni = cs; we_ni = we; bw_ni = bw; addr_i = a; oe_ni = oe;
    data_i = DW'(cyc * 691 + 81);
    cyc++;
    @(posedge clk_i);
    if (!cen) model_edge(ld, cs, we, bw, a);
    @(negedge clk_i);
    checks++;
    if (data_oe_o !== (exp_drv && !oe)) begin
      errors++;
      $display("FAIL %s: data_oe_o actual=%0b expected=%0b (cyc %0d)", tag, data_oe_o, exp_drv && !oe, cyc);
    end
    if (exp_drv) begin
      checks++;
      if (data_o !== exp_data) begin
        errors++;
        $display("FAIL %s: data_o actual=%h expected=%h (cyc %0d)", tag, data_o, exp_data, cyc);
      end
    end
  endtask

  task automatic wr(string tag, logic [AW-1:0] a, logic [NB-1:0] bw);
    step(tag, 0, 0, 3'b000, 0, bw, a, 0);
  endtask

  task automatic rd(string tag, logic [AW-1:0] a);
    step(tag, 0, 0, 3'b000, 1, '1, a, 0);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 3'b100, 1, '1, '0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R11: reset state
    checks++;
    if (data_oe_o !== 1'b0) begin
      errors++;
      $display("FAIL R11: data_oe_o actual=%0b expected=0", data_oe_o);
    end
    rst_ni = 1'b1;
    idle("R11");
    idle("R11");

    // R2: full-word fill of every address, R1: read back
    for (int a = 0; a < DEPTH; a++) wr("R2", AW'(a), 2'b00);
    idle("R6"); idle("R6");
    for (int a = 0; a < DEPTH; a++) rd("R1", AW'(a));
    idle("R6"); idle("R6");

    // R4: every byte-select combination
    for (int a = 0; a < DEPTH; a++) wr("R4", AW'(a), NB'(a));
    idle("R4"); idle("R4");
    for (int a = 0; a < DEPTH; a++) rd("R4", AW'(a));
    idle("R4"); idle("R4");

    // R3: alternate write and read each edge
    for (int i = 0; i < DEPTH; i++) begin
      wr("R3", AW'(i), 2'b00);
      rd("R3", AW'((i + 5) % DEPTH));
    end
    idle("R3"); idle("R3");

    // R9: read right behind a partial write to the same word
    for (int i = 0; i < DEPTH; i++) begin
      wr("R9", AW'(i), NB'(i % 3));
      rd("R9", AW'(i));
    end
    idle("R9"); idle("R9");

    // R5: stalls inside a write and a read
    wr("R5", 4'd3, 2'b00);
    for (int k = 0; k < 3; k++) step("R5", 1, 0, 3'b000, 0, 2'b00, 4'd7, 0);
    rd("R5", 4'd3);
    for (int k = 0; k < 2; k++) step("R5", 1, 0, 3'b000, 0, 2'b00, 4'd3, 0);
    idle("R5");
    for (int k = 0; k < 4; k++) step("R5", 1, 1, 3'b000, 0, 2'b00, 4'd3, 0);
    idle("R5");
    rd("R5", 4'd7);
    rd("R5", 4'd3);
    idle("R5"); idle("R5");

    // R6: each select alone blocks a start; advance after deselect issues nothing
    rd("R6", 4'd1);
    step("R6", 0, 0, 3'b001, 0, 2'b00, 4'd1, 0);
    rd("R6", 4'd2);
    step("R6", 0, 0, 3'b010, 0, 2'b00, 4'd2, 0);
    rd("R6", 4'd3);
    step("R6", 0, 0, 3'b100, 0, 2'b00, 4'd3, 0);
    step("R6", 0, 1, 3'b000, 0, 2'b00, 4'd3, 0);
    rd("R6", 4'd4);
    idle("R6"); idle("R6");

    // R10 / R7: burst write from 9 (9,10,11,8) then one extra advance
    wr("R7", 4'd9, 2'b00);
    for (int k = 0; k < 4; k++) step("R7", 0, 1, 3'b111, 0, 2'b00, 4'd0, 0);
    idle("R10"); idle("R10");
    // R10: burst read from 10 (10,11,8,9)
    rd("R10", 4'd10);
    for (int k = 0; k < 4; k++) step("R10", 0, 1, 3'b111, 1, 2'b11, 4'd0, 0);
    idle("R10"); idle("R10");
    for (int a = 8; a < 12; a++) rd("R10", AW'(a));
    idle("R10"); idle("R10");

    // R8: output enable override in a read slot
    rd("R8", 4'd5);
    step("R8", 0, 0, 3'b000, 1, 2'b11, 4'd6, 1);
    step("R8", 0, 0, 3'b100, 1, 2'b11, 4'd0, 0);
    idle("R8");

    finish_run();
  end
endmodule